// File: doc/BRIEF.md
# SPI Flash Identifier Reader

This block is an SPI controller that fetches a 16-bit identifier from a serial flash device. A one-cycle start pulse makes it pull chip select low and send a 32-bit header: an 8-bit command, which defaults to 0x90, then a 24-bit address. The address is all zero except bit 0, which an input selects. The block then clocks in two bytes, packs them into one 16-bit word, releases chip select and raises a done pulse.

The serial clock comes from the system clock through a prescaler. The prescaler is captured when start is accepted. The idle level of the serial clock is selectable: low for mode 0 and high for mode 3. In both modes data is launched while the serial clock is low and sampled on its rising edge. Both data directions are MSB first. A busy flag covers the whole transaction, including an enforced chip-select-high interval at the end of it.

Top module: `spi_id_reader`

## Requirements
- R1: During reset and on leaving it, cs_n is 1, busy is 0, done is 0, id_out is 0 and sclk equals cpol.
- R2: After an accepted start, cs_n falls before the first sclk edge. While cs_n is low, mosi carries, MSB first, the command byte 0x90, two 0x00 bytes, and a last byte of 7 zero bits followed by addr_lsb in bit 0.
- R3: Each transaction produces exactly 48 rising sclk edges while cs_n is low: 32 for the header and 16 for the read.
- R4: miso is sampled on rising sclk edges. The first byte read (edges 33 to 40) becomes id_out[15:8] and the second byte becomes id_out[7:0]. With addr_lsb clear, a flash answers with the manufacturer code first; with addr_lsb set, it answers with the device code first.
- R5: mosi is 0 at every rising sclk edge of the read phase.
- R6: sclk rests at cpol (0 for mode 0, 1 for mode 3) whenever cs_n is high. sclk only toggles while cs_n is low.
- R7: Consecutive rising sclk edges are exactly `prescale` system cycles apart, for any even prescale of 2 or more. Divide-by-8 is included.
- R8: busy rises in the cycle after an accepted start and stays high until done. A start pulse while busy is ignored and does not begin a second transaction.
- R9: done is high for exactly one cycle. In that cycle cs_n is 1 and busy is 0. Between a rise of cs_n and the next fall of cs_n there are at least `prescale` system cycles.
- R10: id_out changes only in the done cycle and holds its value through the next transaction until that transaction's done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to read the identifier |
| prescale | input | PW | System cycles per serial clock period (even, 2 or more) |
| cpol | input | 1 | Serial clock idle level: 0 for mode 0, 1 for mode 3 |
| addr_lsb | input | 1 | Bit 0 of the transmitted address |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| id_out | output | 16 | First read byte in the upper half, second in the lower half |

## Verification
Serial-side results are checked as they happen. A flash model in the bench counts rising sclk edges, takes the header from mosi on those edges, and drives miso on falling edges. It also timestamps each rising edge and each change of cs_n against a system-cycle counter, so that clock periods and the chip-select gap are measured in cycles. The 16-bit result is due in the done cycle, which comes 2·(prescale/2) system cycles after cs_n rises. The bench waits for done on falling clock edges and reads id_out, busy and cs_n in that same half cycle. It checks that done is gone one cycle later. The ignored-start and hold checks sample the ports in the middle of a transaction, before the next done can occur.

// File: rtl/spi_id_reader.sv
module spi_id_reader #(
  parameter int          PW       = 8,
  parameter logic [7:0]  OPCODE   = 8'h90,
  parameter int          HDR_BITS = 32,
  parameter int          RD_BITS  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PW-1:0]      prescale,
  input  logic               cpol,
  input  logic               addr_lsb,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               cs_n,
  output logic               busy,
  output logic               done,
  output logic [RD_BITS-1:0] id_out
);

  localparam int NB = HDR_BITS + RD_BITS;
  localparam int BW = $clog2(NB);
  localparam logic [BW-1:0] LAST_BIT  = BW'(NB - 1);
  localparam logic [BW-1:0] FIRST_RD  = BW'(HDR_BITS);

  typedef enum logic [2:0] {IDLE, SETUP, XFER, HOLD, GAP} st_t;

  st_t                 st;
  logic [PW-1:0]       cnt;
  logic [PW-2:0]       half_q;
  logic [BW-1:0]       bitn;
  logic                hi;
  logic [HDR_BITS-1:0] tx;
  logic [RD_BITS-1:0]  rx;
  logic [PW-1:0]       tgt;

  assign tgt  = (st == GAP) ? ({half_q, 1'b0} - PW'(1)) : ({1'b0, half_q} - PW'(1));
  assign sclk = (st == XFER) ? hi : cpol;
  assign mosi = (st != IDLE) && (bitn < FIRST_RD) && tx[HDR_BITS-1];
  assign cs_n = !(st == SETUP || st == XFER || st == HOLD);
  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      half_q <= '0;
      bitn   <= '0;
      hi     <= 1'b0;
      tx     <= '0;
      rx     <= '0;
      done   <= 1'b0;
      id_out <= '0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          st     <= SETUP;
          cnt    <= '0;
          bitn   <= '0;
          hi     <= 1'b0;
          half_q <= (prescale < PW'(4)) ? (PW-1)'(1) : prescale[PW-1:1];
          tx     <= {OPCODE, {(HDR_BITS-9){1'b0}}, addr_lsb};
        end
      end else if (cnt != tgt) begin
        cnt <= cnt + PW'(1);
      end else begin
        cnt <= '0;
        if (st == SETUP) begin
          st <= XFER;
        end else if (st == XFER) begin
          if (!hi) begin
            hi <= 1'b1;
            if (bitn >= FIRST_RD) rx <= {rx[RD_BITS-2:0], miso};
          end else begin
            hi <= 1'b0;
            tx <= tx << 1;
            if (bitn == LAST_BIT) st <= HOLD;
            else                  bitn <= bitn + BW'(1);
          end
        end else if (st == HOLD) begin
          st <= GAP;
        end else begin
          st     <= IDLE;
          done   <= 1'b1;
          id_out <= rx;
        end
      end
    end
  end

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk == cpol);
  assert_clock_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $stable(cpol)) |-> !cs_n);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(id_out));

endmodule

// File: tb/spi_id_reader_test.sv
module spi_id_reader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  prescale = 8'd8;
  logic        cpol = 1'b0;
  logic        addr_lsb = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, mosi, cs_n, busy, done;
  logic [15:0] id_out;

  spi_id_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .prescale(prescale), .cpol(cpol),
    .addr_lsb(addr_lsb), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done), .id_out(id_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit over   = 0;

  always @(posedge clk) cyc++;

  // flash model
  logic [7:0]  man_r = 8'h00, dev_r = 8'h00;
  logic [15:0] resp;
  logic [31:0] hdr;
  int n = 0, falls = 0, last_rise = 0, period_bad = 0, mosi_bad = 0;
  int cs_rise_cyc = 0, gap = 0;

  assign resp = addr_lsb ? {dev_r, man_r} : {man_r, dev_r};

  always @(negedge cs_n) begin
    falls++; n = 0; period_bad = 0; mosi_bad = 0; hdr = '0;
    gap = cyc - cs_rise_cyc;
  end
  always @(posedge cs_n) cs_rise_cyc = cyc;

  always @(posedge sclk) if (!cs_n) begin
    if (n > 0 && (cyc - last_rise) != int'(prescale)) period_bad++;
    last_rise = cyc;
    if (n < 32) hdr = {hdr[30:0], mosi};
    else if (mosi !== 1'b0) mosi_bad++;
    n++;
  end

  always @(negedge sclk) if (!cs_n && n >= 32 && n < 48) miso <= resp[47-n];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, "R9 done seen", {31'b0, done}, 32'h1);
  endtask

  task automatic full_txn(input logic c, input logic a, input logic [7:0] p,
                          input logic [7:0] m, input logic [7:0] d);
    logic [15:0] exp_id;
    @(negedge clk);
    cpol = c; addr_lsb = a; prescale = p; man_r = m; dev_r = d;
    exp_id = a ? {d, m} : {m, d};
    @(negedge clk);
    chk(sclk == c, "R6 idle level", {31'b0, sclk}, {31'b0, c});
    pulse_start();
    chk(busy, "R8 busy after start", {31'b0, busy}, 32'h1);
    wait_done();
    chk(id_out == exp_id, "R4 id packing", {16'b0, id_out}, {16'b0, exp_id});
    chk(hdr == {8'h90, 16'h0, 7'b0, a}, "R2 header", hdr, {8'h90, 16'h0, 7'b0, a});
    chk(n == 48, "R3 edge count", n, 48);
    chk(mosi_bad == 0, "R5 mosi low on read", mosi_bad, 0);
    chk(period_bad == 0, "R7 sclk period", period_bad, 0);
    chk(cs_n && !busy, "R9 released at done", {30'b0, cs_n, busy}, 32'h2);
    @(negedge clk);
    chk(!done, "R9 done one cycle", {31'b0, done}, 32'h0);
  endtask

  // cpol, addr_lsb, prescale, manufacturer, device
  localparam int NV = 5;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd8, 8'hEF, 8'h17},
    {1'b1, 1'b0, 8'd8, 8'hC2, 8'h18},
    {1'b0, 1'b1, 8'd2, 8'hEF, 8'h17},
    {1'b1, 1'b1, 8'd4, 8'h5A, 8'hA5},
    {1'b0, 1'b0, 8'd6, 8'h80, 8'h01}
  };

  initial begin
    #1_000_000;
    if (!over) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    int f0;
    repeat (3) @(negedge clk);
    chk(cs_n && !busy && !done && id_out == 16'h0 && sclk == cpol, "R1 reset state",
        {id_out, 12'b0, cs_n, busy, done, sclk}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy && id_out == 16'h0, "R1 after reset", {id_out, 14'b0, cs_n, busy}, 32'h2);

    for (int i = 0; i < NV; i++)
      full_txn(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    // R8: start while busy is ignored
    @(negedge clk);
    cpol = 1'b0; addr_lsb = 1'b0; prescale = 8'd8; man_r = 8'h11; dev_r = 8'h22;
    f0 = falls;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_done();
    repeat (40) @(negedge clk);
    chk(falls == f0 + 1, "R8 restart ignored", falls - f0, 1);
    chk(!busy && cs_n && n == 48, "R8 no second frame", {30'b0, busy, cs_n}, 32'h1);

    // R10: result holds across next transaction; R9 chip-select gap back to back
    held = id_out;
    man_r = 8'h33; dev_r = 8'h44;
    pulse_start();
    wait_done();
    @(negedge clk);
    man_r = 8'h55; dev_r = 8'h66;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy && id_out == 16'h3344, "R10 hold mid-frame", {16'b0, id_out}, 32'h3344);
    chk(gap >= 8, "R9 cs high gap", gap, 8);
    wait_done();
    chk(id_out == 16'h5566 && held == 16'h1122, "R10 new result at done", {held, id_out}, 32'h11225566);

    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule